// File: doc/BRIEF.md
# Floating-Point Control Register with Exception Summary

This block holds the 64-bit control and status word of a floating-point unit. Software moves a 64-bit operand into it with a one-cycle write strobe. The block keeps only the architected field, clears every other bit, and then derives the top bit as a summary flag. The summary flag is the OR of the exception-status bits that survived the mask, so the written value of the top bit never reaches storage.

The stored word is driven on a 64-bit read port at all times. A move-from operation simply samples that port. Reset is synchronous and clears the whole word.

Top module: `fpctl_reg`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, the stored word becomes all zeros, and `rd_data` reads 0 after that edge.
- R2: On a write (`wr_en` high at a rising edge), bits 62 down to 47 of `wr_data` are stored unchanged. Bits 46 down to 0 are stored as zero, whatever was written to them.
- R3: After masking, if any of bits 57 down to 52 is one, bit 63 of the stored word is set to one.
- R4: If bits 57 down to 52 of `wr_data` are all zero, bit 63 is stored as zero, even when bit 63 of `wr_data` is one. Bits 46 down to 0 never set bit 63.
- R5: With `wr_en` low, the stored word keeps its value, and `wr_data` has no effect on it.
- R6: A write takes effect at the clock edge where `wr_en` is sampled high. `rd_data` shows the new word from the next cycle on.
- R7: `rd_data` always presents all 64 bits of the stored word, unaltered.
- R8: When `rst` and `wr_en` are both high at the same edge, reset wins and the stored word becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the move-to path |
| wr_data | input | 64 | Operand for the move-to path |
| rd_data | output | 64 | Stored word for the move-from path |

## Verification
The bench writes words that set the top bit with no status bit, and expects the top bit to come back cleared. A design that copied bit 63 through would return it set. It writes words with each status bit set on its own, and words with only the low field set. A summary taken over the wrong bit range would either miss a flag or raise bit 63 from low-field data. It also drives `wr_data` while `wr_en` is low, and asserts reset together with a write. A design that loaded on every cycle, or gave the write priority over reset, would change the read value.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;

  localparam int CTL_W = 64;

  typedef logic [CTL_W-1:0] ctl_word_t;

  // Contiguous ones from bit lo up to bit hi inclusive.
  function automatic ctl_word_t span_mask(input int hi, input int lo);
    ctl_word_t m;
    m = '0;
    for (int i = 0; i < CTL_W; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Reduction over a field: any bit set inside [hi:lo].
  function automatic logic any_in_span(input ctl_word_t w, input int hi, input int lo);
    return |(w & span_mask(hi, lo));
  endfunction

  // Place the summary flag at bit pos of a word whose bit pos is already clear.
  function automatic ctl_word_t with_flag(input ctl_word_t w, input int pos, input logic f);
    ctl_word_t r;
    r = w;
    r[pos] = f;
    return r;
  endfunction

endpackage

// File: rtl/fpctl_field_mask.sv
module fpctl_field_mask
  import fpctl_pkg::*;
#(
  parameter int KEEP_HI = 62,
  parameter int KEEP_LO = 47
) (
  input  ctl_word_t raw_i,
  output ctl_word_t kept_o
);

  // Per-bit keep decision, chosen at elaboration.
  for (genvar b = 0; b < CTL_W; b++) begin : g_bit
    if (b >= KEEP_LO && b <= KEEP_HI) begin : g_keep
      assign kept_o[b] = raw_i[b];
    end else begin : g_drop
      assign kept_o[b] = 1'b0;
    end
  end

endmodule

// File: rtl/fpctl_summary.sv
module fpctl_summary
  import fpctl_pkg::*;
#(
  parameter int STAT_HI = 57,
  parameter int STAT_LO = 52,
  parameter int SUM_BIT = 63
) (
  input  ctl_word_t kept_i,
  output logic      status_hit_o,
  output ctl_word_t word_o
);

  assign status_hit_o = any_in_span(kept_i, STAT_HI, STAT_LO);
  assign word_o       = with_flag(kept_i, SUM_BIT, status_hit_o);

endmodule

// File: rtl/fpctl_store.sv
module fpctl_store
  import fpctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load_i,
  input  ctl_word_t d_i,
  output ctl_word_t q_o
);

  ctl_word_t q_r;

  always_ff @(posedge clk) begin
    if (rst)         q_r <= '0;
    else if (load_i) q_r <= d_i;
  end

  assign q_o = q_r;

endmodule

// File: rtl/fpctl_reg.sv
module fpctl_reg
  import fpctl_pkg::*;
#(
  parameter int KEEP_HI = 62,
  parameter int KEEP_LO = 47,
  parameter int STAT_HI = 57,
  parameter int STAT_LO = 52,
  parameter int SUM_BIT = 63
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [63:0] wr_data,
  output logic [63:0] rd_data
);

  localparam ctl_word_t LIVE_MASK = span_mask(KEEP_HI, KEEP_LO) | span_mask(SUM_BIT, SUM_BIT);

  // Named internal events, exposed for the assertions.
  ctl_word_t kept_w;
  logic      status_hit_w;
  ctl_word_t next_word_w;
  logic      load_w;

  assign load_w = wr_en;

  fpctl_field_mask #(.KEEP_HI(KEEP_HI), .KEEP_LO(KEEP_LO)) u_mask (
    .raw_i  (wr_data),
    .kept_o (kept_w)
  );

  fpctl_summary #(.STAT_HI(STAT_HI), .STAT_LO(STAT_LO), .SUM_BIT(SUM_BIT)) u_sum (
    .kept_i       (kept_w),
    .status_hit_o (status_hit_w),
    .word_o       (next_word_w)
  );

  fpctl_store u_store (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_w),
    .d_i    (next_word_w),
    .q_o    (rd_data)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> rd_data == '0); // R1
  AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~LIVE_MASK) == '0); // R2
  AST_SUMMARY_TRACKS: assert property (@(posedge clk) disable iff (rst)
    rd_data[SUM_BIT] == any_in_span(rd_data, STAT_HI, STAT_LO)); // R3
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == $past(next_word_w)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data)); // R5
  AST_NO_SUMMARY_FROM_SIGN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !status_hit_w) |=> !rd_data[SUM_BIT]); // R4

endmodule

// File: tb/tb_fpctl_reg.sv
`timescale 1ns/1ps
module tb_fpctl_reg;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [63:0] rd_data;

  always #2 clk = ~clk;

  fpctl_reg dut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  typedef struct {
    int          due;
    logic [63:0] exp;
    string       req;
  } item_t;

  item_t       sb[$];
  int          cyc = 0;
  int          total = 0;
  int          bad = 0;
  logic [63:0] model = '0;
  bit          finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference: keep 62..47, then bit 63 = OR of 57..52.
  function automatic logic [63:0] ref_word(input logic [63:0] d);
    logic [63:0] k;
    k = {1'b0, d[62:47], 47'd0};
    if (k[57:52] != 6'd0) k[63] = 1'b1;
    return k;
  endfunction

  // Driver: called just after a falling edge; result due one edge later.
  task automatic drive(input logic r, input logic we, input logic [63:0] d, input string req);
    item_t it;
    rst = r; wr_en = we; wr_data = d;
    if (r) model = '0;
    else if (we) model = ref_word(d);
    it.due = cyc + 1; it.exp = model; it.req = req;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compares items whose cycle has come.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (rd_data !== it.exp) begin
        bad++;
        $display("FAIL %s: rd_data=%h expected=%h", it.req, rd_data, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0;
    @(negedge clk);
    drive(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R1 reset");
    drive(0, 0, 64'h0, "R1 reset hold");
    // R2: all ones -> field kept, status present -> summary set
    drive(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R2 all ones");
    // R5: idle with noise on wr_data
    drive(0, 0, 64'h0000_0000_0000_0000, "R5 ignore data");
    drive(0, 0, 64'h1234_5678_9ABC_DEF0, "R5 ignore data");
    // R4: sign bit only -> nothing stored
    drive(0, 1, 64'h8000_0000_0000_0000, "R4 sign only");
    // R4: low field only cannot raise summary
    drive(0, 1, 64'h0000_7FFF_FFFF_FFFF, "R4 low field");
    // R2: field outside status range, no summary
    drive(0, 1, 64'h7C0F_8000_0000_0000, "R2 nonstatus field");
    // R3: each status bit alone
    for (int b = 52; b <= 57; b++) begin
      drive(0, 1, 64'd1 << b, "R3 single status");
    end
    // R4: bit 63 with a non-status field bit
    drive(0, 1, 64'h8400_8000_0000_0000, "R4 sign plus field");
    // R6: back to back writes, each seen next cycle
    drive(0, 1, 64'h0010_0000_0000_0000, "R6 back to back");
    drive(0, 1, 64'h4000_0000_0000_0000, "R6 back to back");
    // R7: full word readback, held across idle cycles
    drive(0, 1, 64'h7FFF_8000_0000_0000, "R7 full field");
    drive(0, 0, 64'hAAAA_AAAA_AAAA_AAAA, "R7 readback hold");
    // R8: reset beats a simultaneous write
    drive(1, 1, 64'h7FFF_FFFF_FFFF_FFFF, "R8 reset priority");
    drive(0, 0, 64'h0, "R8 after reset");
    @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule